// File: doc/BRIEF.md
# CHR-Line Reuse Bank Extender

Some boards carry only 8 KB of CHR RAM. On those boards the upper bits of the two 5-bit CHR bank registers do not address CHR memory. This block turns those spare bits into PRG-side address and control lines. It produces a 256 KB outer-bank line for PRG ROM, bank lines for PRG RAM, and a PRG RAM disable. It also passes through the low CHR bank line that the 8 KB CHR RAM still needs.

The block picks one CHR register as the source for every output:

- In 8 KB CHR mode, bank register 0 is always the source.
- In 4 KB mode, PPU address line 12 picks the register for the current fetch. The derived PRG lines can therefore change while the PPU renders.

A 3-bit parameter selects the board wiring:

| Code | Board wiring |
|------|--------------|
| 0 | Outer ROM bank only |
| 1 | 16 KB PRG RAM |
| 2 | 32 KB PRG RAM plus outer ROM bank |
| 3 | RAM-disable bit |
| 4 to 7 | Plain: only the CHR line is produced |

The outputs are combinational, with no register stage. The base PRG/CHR address translator and the memories are outside this block.

Top module: `chr_reuse_extender`

## Requirements
- R1: When `chrMode4k` is 0, every derived output comes from `chrBank0`, whatever the values of `ppuA12` and `chrBank1`.
- R2: When `chrMode4k` is 1, the outputs come from `chrBank0` while `ppuA12` is 0 and from `chrBank1` while `ppuA12` is 1.
- R3: `chrA12Out` equals bit 0 of the active register for every board type.
- R4: For board types 0 and 2, `prgRomA18` equals bit 4 of the active register. For all other types it is 0. The line is not affected by the base PRG bank mode, so it also applies to the fixed bank.
- R5: For board type 2, `prgRamA14` equals bit 3 and `prgRamA13` equals bit 2 of the active register.
- R6: For board type 1, `prgRamA13` equals bit 3 of the active register, and `prgRamA14` is 0.
- R7: For board type 3, `prgRamDisable` is 1 when bit 4 of the active register is 1 or `prgRamOff` is 1. RAM is enabled only when both are 0.
- R8: For board types other than 3, `prgRamDisable` equals `prgRamOff`. A RAM bank line that a board type does not use stays 0: both RAM lines for types 0, 3 and 4 to 7, and `prgRamA14` for type 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| chrBank0 | input | 5 | Value of CHR bank register 0 |
| chrBank1 | input | 5 | Value of CHR bank register 1 |
| chrMode4k | input | 1 | CHR mode: 1 selects two 4 KB banks, 0 selects one 8 KB bank |
| ppuA12 | input | 1 | PPU address line 12 of the current fetch |
| prgRamOff | input | 1 | Bit 4 of the PRG bank register, the RAM disable held there |
| prgRomA18 | output | 1 | PRG ROM outer 256 KB bank line |
| prgRamA14 | output | 1 | PRG RAM address line 14 |
| prgRamA13 | output | 1 | PRG RAM address line 13 |
| prgRamDisable | output | 1 | 1 = PRG RAM disabled (open bus) |
| chrA12Out | output | 1 | CHR RAM address line 12 |

## Verification
The block holds no state, so the only internal error is a wrong source choice or a wrong bit-to-line mapping. Either one shows at the ports in the same cycle the inputs change.

A wrong source choice shows up as outputs that fail to follow `ppuA12` in 4 KB mode, or that do follow it in 8 KB mode. To expose this, the two registers are given values that differ in every bit. A wrong mapping shows up as the wrong line rising. To expose this, the stimulus sets single bits one at a time, and all four board-type variants watch the same inputs.

// File: rtl/chr_reuse_pkg.sv
package chr_reuse_pkg;
  localparam int BANK_W = 5;

  localparam int BIT_CHR   = 0;
  localparam int BIT_RAMLO = 2;
  localparam int BIT_RAMHI = 3;
  localparam int BIT_TOP   = 4;

  localparam logic [2:0] BT_OUTER   = 3'd0;
  localparam logic [2:0] BT_RAM16K  = 3'd1;
  localparam logic [2:0] BT_RAM32K  = 3'd2;
  localparam logic [2:0] BT_DISABLE = 3'd3;

  typedef struct packed {
    logic pickHigh;
    logic pickLow;
  } ctrlStrobes_t;
endpackage

// File: rtl/chr_reuse_ctrl.sv
module chr_reuse_ctrl
  import chr_reuse_pkg::*;
(
  input  logic         chrMode4k,
  input  logic         ppuA12,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.pickHigh = chrMode4k & ppuA12;
    strobes.pickLow  = ~(chrMode4k & ppuA12);
  end

  always_comb begin
    assert_onehot_select_R2: assert ($onehot({strobes.pickHigh, strobes.pickLow}))
      else $error("source select not one-hot");
  end
endmodule

// File: rtl/chr_reuse_datapath.sv
module chr_reuse_datapath
  import chr_reuse_pkg::*;
#(
  parameter logic [2:0] BOARD_TYPE = BT_RAM32K,
  parameter int W = BANK_W
) (
  input  logic         [W-1:0] chrBank0,
  input  logic         [W-1:0] chrBank1,
  input  ctrlStrobes_t         strobes,
  input  logic                 prgRamOff,
  output logic                 prgRomA18,
  output logic                 prgRamA14,
  output logic                 prgRamA13,
  output logic                 prgRamDisable,
  output logic                 chrA12Out
);
  logic [W-1:0] activeReg;

  always_comb begin
    activeReg = ({W{strobes.pickLow}} & chrBank0) | ({W{strobes.pickHigh}} & chrBank1);
  end

  assign chrA12Out = activeReg[BIT_CHR];

  generate
    if (BOARD_TYPE == BT_OUTER) begin : g_outer
      assign prgRomA18     = activeReg[BIT_TOP];
      assign prgRamA14     = 1'b0;
      assign prgRamA13     = 1'b0;
      assign prgRamDisable = prgRamOff;
    end else if (BOARD_TYPE == BT_RAM16K) begin : g_ram16
      assign prgRomA18     = 1'b0;
      assign prgRamA14     = 1'b0;
      assign prgRamA13     = activeReg[BIT_RAMHI];
      assign prgRamDisable = prgRamOff;
    end else if (BOARD_TYPE == BT_RAM32K) begin : g_ram32
      assign prgRomA18     = activeReg[BIT_TOP];
      assign prgRamA14     = activeReg[BIT_RAMHI];
      assign prgRamA13     = activeReg[BIT_RAMLO];
      assign prgRamDisable = prgRamOff;
    end else if (BOARD_TYPE == BT_DISABLE) begin : g_dis
      assign prgRomA18     = 1'b0;
      assign prgRamA14     = 1'b0;
      assign prgRamA13     = 1'b0;
      assign prgRamDisable = prgRamOff | activeReg[BIT_TOP];
    end else begin : g_plain
      assign prgRomA18     = 1'b0;
      assign prgRamA14     = 1'b0;
      assign prgRamA13     = 1'b0;
      assign prgRamDisable = prgRamOff;
    end
  endgenerate

  always_comb begin
    if (!prgRamOff && BOARD_TYPE == BT_DISABLE && !prgRamDisable)
      assert_enable_needs_clear_R7: assert (!(strobes.pickHigh ? chrBank1[BIT_TOP] : chrBank0[BIT_TOP]))
        else $error("RAM enabled with disable bit set");
    if (BOARD_TYPE != BT_DISABLE)
      assert_disable_pass_R8: assert (prgRamDisable == prgRamOff)
        else $error("RAM disable differs from PRG bit");
  end
endmodule

// File: rtl/chr_reuse_extender.sv
module chr_reuse_extender
  import chr_reuse_pkg::*;
#(
  parameter logic [2:0] BOARD_TYPE = BT_RAM32K
) (
  input  logic [BANK_W-1:0] chrBank0,
  input  logic [BANK_W-1:0] chrBank1,
  input  logic              chrMode4k,
  input  logic              ppuA12,
  input  logic              prgRamOff,
  output logic              prgRomA18,
  output logic              prgRamA14,
  output logic              prgRamA13,
  output logic              prgRamDisable,
  output logic              chrA12Out
);
  ctrlStrobes_t strobes;

  chr_reuse_ctrl i_ctrl (
    .chrMode4k (chrMode4k),
    .ppuA12    (ppuA12),
    .strobes   (strobes)
  );

  chr_reuse_datapath #(.BOARD_TYPE(BOARD_TYPE), .W(BANK_W)) i_dp (
    .chrBank0      (chrBank0),
    .chrBank1      (chrBank1),
    .strobes       (strobes),
    .prgRamOff     (prgRamOff),
    .prgRomA18     (prgRomA18),
    .prgRamA14     (prgRamA14),
    .prgRamA13     (prgRamA13),
    .prgRamDisable (prgRamDisable),
    .chrA12Out     (chrA12Out)
  );

  always_comb begin
    if (!chrMode4k)
      assert_8k_uses_bank0_R1: assert (chrA12Out == chrBank0[BIT_CHR])
        else $error("8 KB mode not sourced from bank 0");
    if (chrMode4k && ppuA12)
      assert_4k_high_uses_bank1_R3: assert (chrA12Out == chrBank1[BIT_CHR])
        else $error("4 KB upper fetch not sourced from bank 1");
    if (BOARD_TYPE != BT_OUTER && BOARD_TYPE != BT_RAM32K)
      assert_a18_quiet_R4: assert (!prgRomA18)
        else $error("outer bank line driven on board without it");
  end
endmodule

// File: tb/test_chr_reuse_extender.sv
module test_chr_reuse_extender;
  logic clk = 1'b0;
  logic rst = 1'b1;
  int checks = 0;
  int errors = 0;

  logic [4:0] b0 = '0, b1 = '0;
  logic mode4k = 1'b0, a12 = 1'b0, ramOff = 1'b0;

  logic [4:0] o32, o16, oDis, oOut, oPlain;

  always #5 clk = ~clk;

  chr_reuse_extender #(.BOARD_TYPE(3'd2)) i_chr_reuse_extender (
    .chrBank0(b0), .chrBank1(b1), .chrMode4k(mode4k), .ppuA12(a12), .prgRamOff(ramOff),
    .prgRomA18(o32[4]), .prgRamA14(o32[3]), .prgRamA13(o32[2]),
    .prgRamDisable(o32[1]), .chrA12Out(o32[0]));
  chr_reuse_extender #(.BOARD_TYPE(3'd1)) i_chr_reuse_extender_16k (
    .chrBank0(b0), .chrBank1(b1), .chrMode4k(mode4k), .ppuA12(a12), .prgRamOff(ramOff),
    .prgRomA18(o16[4]), .prgRamA14(o16[3]), .prgRamA13(o16[2]),
    .prgRamDisable(o16[1]), .chrA12Out(o16[0]));
  chr_reuse_extender #(.BOARD_TYPE(3'd3)) i_chr_reuse_extender_dis (
    .chrBank0(b0), .chrBank1(b1), .chrMode4k(mode4k), .ppuA12(a12), .prgRamOff(ramOff),
    .prgRomA18(oDis[4]), .prgRamA14(oDis[3]), .prgRamA13(oDis[2]),
    .prgRamDisable(oDis[1]), .chrA12Out(oDis[0]));
  chr_reuse_extender #(.BOARD_TYPE(3'd0)) i_chr_reuse_extender_out (
    .chrBank0(b0), .chrBank1(b1), .chrMode4k(mode4k), .ppuA12(a12), .prgRamOff(ramOff),
    .prgRomA18(oOut[4]), .prgRamA14(oOut[3]), .prgRamA13(oOut[2]),
    .prgRamDisable(oOut[1]), .chrA12Out(oOut[0]));
  chr_reuse_extender #(.BOARD_TYPE(3'd6)) i_chr_reuse_extender_plain (
    .chrBank0(b0), .chrBank1(b1), .chrMode4k(mode4k), .ppuA12(a12), .prgRamOff(ramOff),
    .prgRomA18(oPlain[4]), .prgRamA14(oPlain[3]), .prgRamA13(oPlain[2]),
    .prgRamDisable(oPlain[1]), .chrA12Out(oPlain[0]));

  // Vector: b0, b1, mode4k, a12, ramOff, expected {a18,a14,a13,dis,a12} for board type 2
  typedef struct packed {
    logic [4:0] v0;
    logic [4:0] v1;
    logic m;
    logic a;
    logic r;
    logic [4:0] exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{5'b00000, 5'b11111, 1'b0, 1'b1, 1'b0, 5'b00000}, // R1
    '{5'b10101, 5'b00000, 1'b0, 1'b0, 1'b0, 5'b10101}, // R4 R5
    '{5'b10101, 5'b01010, 1'b0, 1'b1, 1'b0, 5'b10101}, // R1
    '{5'b10101, 5'b01010, 1'b1, 1'b1, 1'b0, 5'b01000}, // R2
    '{5'b10101, 5'b01010, 1'b1, 1'b0, 1'b0, 5'b10101}, // R2
    '{5'b01100, 5'b00000, 1'b0, 1'b0, 1'b1, 5'b01110}, // R5 R8
    '{5'b11111, 5'b00000, 1'b1, 1'b1, 1'b0, 5'b00000}, // R2
    '{5'b00000, 5'b11111, 1'b1, 1'b1, 1'b0, 5'b11101}  // R3
  };

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic apply(input logic [4:0] v0, input logic [4:0] v1,
                       input logic m, input logic a, input logic r);
    @(posedge clk);
    b0 = v0; b1 = v1; mode4k = m; a12 = a; ramOff = r;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 idle", o32, 5'b00000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].v0, VECS[i].v1, VECS[i].m, VECS[i].a, VECS[i].r);
      check("R1/R2 table", o32, VECS[i].exp);
    end

    // R6 16 KB RAM board: bit 3 -> RAM A13 only
    apply(5'b01000, 5'b00000, 1'b0, 1'b0, 1'b0);
    check("R6", o16, 5'b00100);
    apply(5'b10101, 5'b00000, 1'b0, 1'b0, 1'b0);
    check("R6", o16, 5'b00001);
    apply(5'b00000, 5'b01000, 1'b1, 1'b1, 1'b0);
    check("R6", o16, 5'b00100);

    // R7 disable board
    apply(5'b10000, 5'b00000, 1'b0, 1'b0, 1'b0);
    check("R7", oDis, 5'b00010);
    apply(5'b00000, 5'b00000, 1'b0, 1'b0, 1'b1);
    check("R7", oDis, 5'b00010);
    apply(5'b01111, 5'b00000, 1'b0, 1'b0, 1'b0);
    check("R7", oDis, 5'b00001);
    apply(5'b00000, 5'b10000, 1'b1, 1'b1, 1'b0);
    check("R7", oDis, 5'b00010);
    apply(5'b00000, 5'b10000, 1'b1, 1'b0, 1'b0);
    check("R7", oDis, 5'b00000);

    // R4 outer board and plain board
    apply(5'b11101, 5'b00000, 1'b0, 1'b1, 1'b0);
    check("R4", oOut, 5'b10001);
    check("R8 plain", oPlain, 5'b00001);
    apply(5'b11101, 5'b00000, 1'b0, 1'b1, 1'b1);
    check("R8", oOut, 5'b10011);
    check("R8 plain", oPlain, 5'b00011);
    check("R3", {4'b0, o16[0]}, 5'b00001);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule